// File: doc/BRIEF.md
# Masked Device Interrupt Router

This block sits between a set of device interrupt lines and the processors of a chip. For each device source it keeps a routing entry (which CPU to interrupt and which vector to deliver) and a control entry (a mask bit and a pending bit). When an unmasked source raises its line, the router accepts it. It marks the source pending, masks the source again by itself, and emits a single-cycle post that carries the routed CPU number and vector. A masked source is ignored. Its line can stay high and nothing happens until software clears the mask.

Software configures and inspects the entries through a simple register bus. Each entry takes one 8-byte slot. Routing slots start at offset zero. Control slots start at a separate, parameterized base. A read returns its data one cycle after the request. An access to an offset that maps to no slot reads as zero and raises an error flag. When several unmasked sources fire at once, the lowest index is served first. The others stay held at the input and are served in the following cycles.

Top module: `irq_router`

## Requirements
- R1: After reset every source reads back masked and not pending (control read value 0x4), with CPU and vector both zero (routing read value 0x0).
- R2: A routing write takes the target CPU from data bits 12:8 and the vector from bits 5:0 and ignores all other bits. A routing read returns the CPU in bits 12:8, the vector in bits 5:0, and zero elsewhere.
- R3: A control write sets the mask from data bit 2. Bit 1 set to one clears pending. Bit 1 at zero leaves pending unchanged. A control read returns the mask in bit 2, pending in bit 0, and zero elsewhere.
- R4: A device line raised while its source is masked produces no post and leaves that source's pending bit unchanged.
- R5: A line raised on an unmasked source produces, on the next clock edge, `post_valid` high for exactly one cycle with the routed CPU and vector. The source is then both pending and masked.
- R6: Among unmasked sources that fire in the same cycle, the lowest index is posted first. The remaining sources, held high, are posted one per cycle in ascending index order.
- R7: `reg_rvalid` and the read data appear one cycle after a cycle with `reg_rd` high. In every other cycle `reg_rvalid` is low.
- R8: A read or write to an offset outside both slot ranges pulses `reg_err` one cycle later. Such a read returns zero, and such a write changes no entry.
- R9: Entry index is the offset (relative to the array base) shifted right by 3. The low three address bits are ignored. Routing slots begin at 0 and control slots begin at `CTRL_BASE`.
- R10: If a source is accepted in the same cycle that software writes its control slot, the acceptance wins and the source ends pending and masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dev_irq | input | NUM_SRC | Device interrupt lines, held high until served |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| reg_err | output | 1 | Unmapped access flag, one cycle after the access |
| post_valid | output | 1 | One-cycle interrupt post |
| post_cpu | output | 5 | Target CPU of the post |
| post_vec | output | 6 | Vector of the post |

## Verification
Every result of this block lands exactly one clock edge after its cause. This holds for a post after an unmasked line rises, for read data and `reg_rvalid` after `reg_rd`, and for `reg_err` after an unmapped access. A control or routing update becomes visible to a read issued in the following cycle. The bench drives all inputs on the falling edge and samples outputs on the next falling edge, which is half a cycle after the single register stage. For the multi-source case it samples one post per falling edge in ascending index order. Masked and same-cycle cases are checked through the post output and a later control read.

// File: rtl/irq_router_pkg.sv
// Package: field layout shared by the router and its helpers.
// Assumes the register format is fixed: CPU field 5 bits, vector field 6 bits.
package irq_router_pkg;
    localparam int CPU_W   = 5;
    localparam int VEC_W   = 6;
    localparam int CPU_LSB = 8;   // CPU field starts at data bit 8
    localparam int MASK_B  = 2;   // control: mask bit
    localparam int CLR_B   = 1;   // control: write-one-to-clear pending
    localparam int PEND_B  = 0;   // control: pending read bit

    typedef struct packed {
        logic [CPU_W-1:0] cpu;
        logic [VEC_W-1:0] vec;
    } route_t;
endpackage

// File: rtl/irq_pick.sv
// Module: lowest-index picker over a request vector.
// Assumes nothing about request timing; purely combinational.
module irq_pick #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     req,
    output logic [N-1:0]     grant,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    // isolate the lowest set bit and encode its position
    always_comb begin
        grant = req & (~req + N'(1));
        any   = |req;
        idx   = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/reg_map_decode.sv
// Module: decodes a byte offset into routing/control slot hits and an index.
// Assumes 8-byte slots; low three offset bits are ignored.
module reg_map_decode #(
    parameter int                NUM_SRC   = 8,
    parameter int                ADDR_W    = 12,
    parameter int                IDX_W     = 3,
    parameter logic [ADDR_W-1:0] CTRL_BASE = 'h100
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_route,
    output logic              hit_ctrl,
    output logic [IDX_W-1:0]  idx
);
    localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(NUM_SRC * 8);

    logic [ADDR_W-1:0] ctl_off;

    // range compare both arrays and derive the slot index
    always_comb begin
        ctl_off   = addr - CTRL_BASE;
        hit_route = (addr < SPAN);
        hit_ctrl  = (addr >= CTRL_BASE) && (ctl_off < SPAN);
        idx       = hit_ctrl ? ctl_off[IDX_W+2:3] : addr[IDX_W+2:3];
    end
endmodule

// File: rtl/irq_router.sv
// Module: masked device interrupt router (top).
// Holds per-source routing and control entries, accepts unmasked device
// lines lowest index first, re-masks on acceptance and posts CPU/vector.
// Assumes device lines are levels held until served, and that reads and
// writes use the single-cycle register bus described in the brief.
module irq_router
    import irq_router_pkg::*;
#(
    parameter int                NUM_SRC   = 8,
    parameter int                ADDR_W    = 12,
    parameter int                DATA_W    = 32,
    parameter logic [ADDR_W-1:0] CTRL_BASE = 'h100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] dev_irq,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               reg_rvalid,
    output logic               reg_err,
    output logic               post_valid,
    output logic [CPU_W-1:0]   post_cpu,
    output logic [VEC_W-1:0]   post_vec
);
    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam int FMT_W = CPU_LSB + CPU_W;

    route_t             route_q [NUM_SRC];
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] pend_q;

    logic               hit_route, hit_ctrl;
    logic [IDX_W-1:0]   slot;
    logic               wr_route, wr_ctrl;
    logic [NUM_SRC-1:0] eligible, acc_onehot;
    logic               acc_any;
    logic [IDX_W-1:0]   acc_idx;
    route_t             wr_fields;
    logic               unused_wbits;

    reg_map_decode #(
        .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .CTRL_BASE(CTRL_BASE)
    ) u_dec (
        .addr(reg_addr), .hit_route(hit_route), .hit_ctrl(hit_ctrl), .idx(slot)
    );

    irq_pick #(.N(NUM_SRC), .IDX_W(IDX_W)) u_pick (
        .req(eligible), .grant(acc_onehot), .any(acc_any), .idx(acc_idx)
    );

    // qualify strobes and gather eligible requests
    always_comb begin
        wr_route      = reg_wr & hit_route;
        wr_ctrl       = reg_wr & hit_ctrl;
        eligible      = dev_irq & ~mask_q;
        wr_fields.cpu = reg_wdata[CPU_LSB +: CPU_W];
        wr_fields.vec = reg_wdata[VEC_W-1:0];
        unused_wbits  = ^{reg_wdata[DATA_W-1:FMT_W], reg_wdata[CPU_LSB-1:VEC_W]};
    end

    // routing entries: software writes only
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_SRC; i++) begin
            if (!rst_n)                                route_q[i] <= '0;
            else if (wr_route && slot == IDX_W'(i))    route_q[i] <= wr_fields;
        end
    end

    // control entries: acceptance overrides a same-cycle software write
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_SRC; i++) begin
            if (!rst_n) begin
                mask_q[i] <= 1'b1;
                pend_q[i] <= 1'b0;
            end else if (acc_onehot[i]) begin
                mask_q[i] <= 1'b1;
                pend_q[i] <= 1'b1;
            end else if (wr_ctrl && slot == IDX_W'(i)) begin
                mask_q[i] <= reg_wdata[MASK_B];
                if (reg_wdata[CLR_B]) pend_q[i] <= 1'b0;
            end
        end
    end

    // post register: one pulse per accepted source
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            post_valid <= 1'b0;
            post_cpu   <= '0;
            post_vec   <= '0;
        end else begin
            post_valid <= acc_any;
            post_cpu   <= acc_any ? route_q[acc_idx].cpu : '0;
            post_vec   <= acc_any ? route_q[acc_idx].vec : '0;
        end
    end

    // read path and error flag, one cycle latency
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata  <= '0;
            reg_rvalid <= 1'b0;
            reg_err    <= 1'b0;
        end else begin
            reg_rvalid <= reg_rd;
            reg_err    <= (reg_rd | reg_wr) & ~hit_route & ~hit_ctrl;
            if (!reg_rd)        reg_rdata <= '0;
            else if (hit_route) reg_rdata <= DATA_W'({route_q[slot].cpu, 2'b00, route_q[slot].vec});
            else if (hit_ctrl)  reg_rdata <= DATA_W'({mask_q[slot], 1'b0, pend_q[slot]});
            else                reg_rdata <= '0;
        end
    end

    // R5
    accept_sets_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_any |=> (post_valid && pend_q[$past(acc_idx)] && mask_q[$past(acc_idx)]));

    // R6
    lowest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_any |-> (eligible[acc_idx] &&
                     ((eligible & ((NUM_SRC'(1) << acc_idx) - NUM_SRC'(1))) == '0)));

    // R7
    read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> reg_rvalid);

    // R7
    no_stray_rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> !reg_rvalid);

    // R8
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rvalid && reg_err) |-> (reg_rdata == '0));

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_disc
        // R4
        masked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (dev_irq[g] && mask_q[g] && !(wr_ctrl && slot == IDX_W'(g)))
            |=> (pend_q[g] == $past(pend_q[g])));
    end
endmodule

// File: tb/sim_irq_router.sv
// Bench: directed scenarios, one task each, self-checking via counters.
module sim_irq_router;
    localparam int NUM_SRC = 8;
    localparam int ADDR_W  = 12;
    localparam int DATA_W  = 32;
    localparam logic [ADDR_W-1:0] CB = 12'h100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NUM_SRC-1:0] dev_irq = '0;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic reg_rvalid, reg_err, post_valid;
    logic [4:0] post_cpu;
    logic [5:0] post_vec;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    irq_router #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_BASE(CB)) u0 (
        .clk(clk), .rst_n(rst_n), .dev_irq(dev_irq), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_rvalid(reg_rvalid), .reg_err(reg_err), .post_valid(post_valid),
        .post_cpu(post_cpu), .post_vec(post_vec)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d, output logic err);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0; err = reg_err;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d, output logic err);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        @(negedge clk); reg_rd = 1'b0;
        chk("R7 rvalid after read", 32'(reg_rvalid), 32'd1);
        d = reg_rdata; err = reg_err;
    endtask

    task automatic expect_post(input string req, input logic v, input logic [4:0] c, input logic [5:0] vec);
        chk(req, {20'd0, post_cpu, post_vec, post_valid}, {20'd0, c, vec, v});
    endtask

    task automatic t_reset();
        logic [31:0] d; logic e;
        for (int i = 0; i < NUM_SRC; i++) begin
            rd(ADDR_W'(i*8), d, e);      chk("R1 route reset", d, 32'h0);
            rd(CB + ADDR_W'(i*8), d, e); chk("R1 control reset", d, 32'h4);
        end
    endtask

    task automatic t_route();
        logic [31:0] d; logic e;
        wr(12'h00B, 32'hFFFF_FFFF, e);
        rd(12'h008, d, e); chk("R2 R9 route field mask, low bits ignored", d, 32'h1F3F);
        wr(12'h038, 32'h0000_0A15, e);
        rd(12'h03F, d, e); chk("R2 route last slot", d, 32'h0A15);
        rd(12'h030, d, e); chk("R9 neighbour untouched", d, 32'h0);
    endtask

    task automatic t_discard();
        logic [31:0] d; logic e;
        @(negedge clk); dev_irq[3] = 1'b1;
        @(negedge clk); expect_post("R4 masked no post", 1'b0, 5'd0, 6'd0);
        @(negedge clk); expect_post("R4 masked no post later", 1'b0, 5'd0, 6'd0);
        dev_irq[3] = 1'b0;
        rd(CB + 12'h018, d, e); chk("R4 masked pending unchanged", d, 32'h4);
    endtask

    task automatic t_accept();
        logic [31:0] d; logic e;
        wr(12'h010, 32'h0000_0321, e);
        wr(CB + 12'h010, 32'h0, e);
        rd(CB + 12'h010, d, e); chk("R3 mask cleared", d, 32'h0);
        @(negedge clk); dev_irq[2] = 1'b1;
        @(negedge clk); expect_post("R5 post on next edge", 1'b1, 5'd3, 6'h21);
        dev_irq[2] = 1'b0;
        @(negedge clk); expect_post("R5 single-cycle post", 1'b0, 5'd0, 6'd0);
        rd(CB + 12'h010, d, e); chk("R5 pending and masked", d, 32'h5);
    endtask

    task automatic t_pend();
        logic [31:0] d; logic e;
        wr(CB + 12'h010, 32'h0, e);
        rd(CB + 12'h010, d, e); chk("R3 bit1 zero keeps pending", d, 32'h1);
        wr(CB + 12'h010, 32'h2, e);
        rd(CB + 12'h010, d, e); chk("R3 bit1 one clears pending", d, 32'h0);
        wr(CB + 12'h010, 32'hFFFF_FFFC, e);
        rd(CB + 12'h010, d, e); chk("R3 read shows mask only", d, 32'h4);
    endtask

    task automatic t_multi();
        logic [31:0] d; logic e;
        wr(12'h028, 32'h0105, e);
        wr(12'h030, 32'h0206, e);
        wr(CB + 12'h010, 32'h0, e);
        wr(CB + 12'h028, 32'h0, e);
        wr(CB + 12'h030, 32'h0, e);
        @(negedge clk); dev_irq = 8'b0110_0100;
        @(negedge clk); expect_post("R6 first lowest index", 1'b1, 5'd3, 6'h21);
        @(negedge clk); expect_post("R6 second index", 1'b1, 5'd1, 6'h05);
        @(negedge clk); expect_post("R6 third index", 1'b1, 5'd2, 6'h06);
        @(negedge clk); expect_post("R6 no further post", 1'b0, 5'd0, 6'd0);
        dev_irq = '0;
        rd(CB + 12'h028, d, e); chk("R6 served source pending", d, 32'h5);
        rd(CB + 12'h030, d, e); chk("R6 served source pending", d, 32'h5);
    endtask

    task automatic t_same();
        logic [31:0] d; logic e;
        wr(12'h020, 32'h0404, e);
        wr(CB + 12'h020, 32'h0, e);
        @(negedge clk);
        dev_irq[4] = 1'b1; reg_wr = 1'b1; reg_addr = CB + 12'h020; reg_wdata = 32'h2;
        @(negedge clk);
        reg_wr = 1'b0; dev_irq[4] = 1'b0;
        expect_post("R10 post despite write", 1'b1, 5'd4, 6'd4);
        rd(CB + 12'h020, d, e); chk("R10 accept wins", d, 32'h5);
    endtask

    task automatic t_unmapped();
        logic [31:0] d; logic e;
        rd(12'h080, d, e);
        chk("R8 gap read zero", d, 32'h0); chk("R8 gap read err", 32'(e), 32'd1);
        rd(CB + 12'h040, d, e);
        chk("R8 past control read err", 32'(e), 32'd1);
        wr(12'h040, 32'hFFFF, e);
        chk("R8 unmapped write err", 32'(e), 32'd1);
        rd(12'h000, d, e);
        chk("R8 entry 0 unchanged", d, 32'h0); chk("R8 mapped read no err", 32'(e), 32'd0);
        @(negedge clk); chk("R7 rvalid idle", 32'(reg_rvalid), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_post("R1 no post after reset", 1'b0, 5'd0, 6'd0);
        t_reset();
        t_route();
        t_discard();
        t_accept();
        t_pend();
        t_multi();
        t_same();
        t_unmapped();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule